// File: doc/BRIEF.md
# Policy-Masked Clock Enable Controller

This block drives one enable line per downstream clock from a small bank of policy masks. Each power policy owns one mask register. Bit c of every mask belongs to clock c, and a set bit means clock c runs while that policy is in force. An external active-policy index picks which mask is applied. The chosen mask is registered onto the enable outputs for as long as the policy engine is running.

Software reaches the block over a plain word-addressed register bus. All writes are guarded by an unlock register at word address 0. Software writes a fixed 24-bit password together with a write-enable flag, and only while that flag is set do the other registers accept data.

Masks are edited in a fixed order. Software first halts the engine through a control register. While halted, the enables keep their last value. Software then rewrites the masks and restarts the engine with a one-shot go command carrying a mode choice. On the cycle after the go, the engine reloads the enables from the selected mask.

Top module: `pmask_clk_ctrl`

## Requirements
- R1: While the engine runs, `clk_en` equals the mask of policy `active_policy`, one clock after that input and mask are sampled. The mask of policy p sits at word address 2+p, and its bit c controls `clk_en[c]`. Reads of a mask address return the stored mask in the low bits.
- R2: A write to address 0 whose bits 31:8 equal 24'hA5C3E1 sets the write-enable flag to data bit 0. A write to address 0 with any other value in bits 31:8 clears the flag. Reading address 0 returns the flag in bit 0 and zeros elsewhere.
- R3: While the write-enable flag is clear, writes to every address other than 0 are dropped. Reads keep returning current contents.
- R4: Writing the control register (address 1) with bit 0 set halts the engine, which reads back as control bit 0 = 1. A mask write changes the mask only while the engine is halted.
- R5: A go command is a control write with bit 0 = 0 and bit 1 = 1, and with exactly one of bit 2 (auto mode) or bit 3 (alternate mode) set, made while the engine is halted. Any other control write starts nothing. The accepted mode reads back in control bit 2, where 1 means alternate.
- R6: After an accepted go, control bit 1 reads 1 for exactly one cycle. On the next edge it clears, the engine leaves the halted state, and `clk_en` loads the selected mask.
- R7: While the engine is halted and no go is pending, `clk_en` holds its value regardless of mask edits or `active_policy` changes.
- R8: Reset leaves the engine running, the write-enable flag clear and every mask all ones. It holds `clk_en` at zero while asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Word address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| active_policy | input | 2 | Index of the policy in force |
| clk_en | output | 16 | Per-clock enable outputs |

## Verification
A wrong write-enable or halt state shows up as mask or control readback that differs from the last accepted write. It is visible on the read bus in the same cycle the register is addressed. A stuck or lost go bit shows up one cycle after the go write: the control readback or the enables disagree with the expected restart. A wrong enable register shows on `clk_en` one cycle after a policy change while the engine runs, or as a change on `clk_en` while the engine is halted.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned ADDR_LOCK  = 0;
  localparam int unsigned ADDR_CTRL  = 1;
  localparam int unsigned ADDR_MASK0 = 2;
  localparam logic [23:0] PASSWORD   = 24'hA5C3E1;

  // control register bit positions
  localparam int unsigned CTL_HALT = 0;
  localparam int unsigned CTL_GO   = 1;
  localparam int unsigned CTL_AUTO = 2;
  localparam int unsigned CTL_ALT  = 3;
endpackage

// File: rtl/pmask_unlock.sv
module pmask_unlock
  import pmask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wen_o
);
  logic wen_q, wen_d;

  always_comb begin
    wen_d = wen_q;
    if (wr_i) begin
      if (wdata_i[31:8] == PASSWORD) wen_d = wdata_i[0];
      else                           wen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wen_q <= 1'b0;
    else        wen_q <= wen_d;
  end

  assign wen_o = wen_q;

  // R2: a bad password always locks
  a_r2_bad_pw_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[31:8] != PASSWORD) |=> !wen_o);
endmodule

// File: rtl/pmask_engine.sv
module pmask_engine
  import pmask_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [3:0] cmd_i,
  output logic       halt_o,
  output logic       go_o,
  output logic       alt_o
);
  logic halt_q, halt_d;
  logic go_q, go_d;
  logic alt_q, alt_d;
  logic go_req;

  assign go_req = wr_i && halt_q && !go_q && !cmd_i[CTL_HALT] && cmd_i[CTL_GO]
                  && (cmd_i[CTL_AUTO] ^ cmd_i[CTL_ALT]);

  always_comb begin
    halt_d = halt_q;
    go_d   = 1'b0;
    alt_d  = alt_q;
    if (go_q)                        halt_d = 1'b0;
    else if (wr_i && cmd_i[CTL_HALT]) halt_d = 1'b1;
    if (go_req) begin
      go_d  = 1'b1;
      alt_d = cmd_i[CTL_ALT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      go_q   <= 1'b0;
      alt_q  <= 1'b0;
    end else begin
      halt_q <= halt_d;
      go_q   <= go_d;
      alt_q  <= alt_d;
    end
  end

  assign halt_o = halt_q;
  assign go_o   = go_q;
  assign alt_o  = alt_q;

  // R6: go is a one-cycle pulse
  a_r6_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !go_o);
  // R6: go releases the halt
  a_r6_go_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !halt_o);
  // R5: no go while running
  a_r5_no_go_running: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_o |=> !go_o);
endmodule

// File: rtl/pmask_bank.sv
module pmask_bank #(
  parameter int unsigned NUM_POLICY = 4,
  parameter int unsigned NUM_CLK    = 16,
  localparam int unsigned POL_W     = (NUM_POLICY > 1) ? $clog2(NUM_POLICY) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_i,
  input  logic [POL_W-1:0]                      idx_i,
  input  logic [NUM_CLK-1:0]                    wdata_i,
  output logic [NUM_POLICY-1:0][NUM_CLK-1:0]    masks_o
);
  for (genvar p = 0; p < NUM_POLICY; p++) begin : g_pol
    logic [NUM_CLK-1:0] m_q, m_d;
    logic               hit;

    assign hit = wr_i && (idx_i == POL_W'(p));

    always_comb begin
      m_d = m_q;
      if (hit) m_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= '1;
      else        m_q <= m_d;
    end

    assign masks_o[p] = m_q;
  end
endmodule

// File: rtl/pmask_clk_ctrl.sv
module pmask_clk_ctrl
  import pmask_pkg::*;
#(
  parameter int unsigned NUM_POLICY = 4,
  parameter int unsigned NUM_CLK    = 16,
  localparam int unsigned POL_W     = (NUM_POLICY > 1) ? $clog2(NUM_POLICY) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_we,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [POL_W-1:0]    active_policy,
  output logic [NUM_CLK-1:0]  clk_en
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // address decode
  logic              hit_lock, hit_ctrl, hit_mask;
  logic [ADDR_W-1:0] mask_off;
  logic [POL_W-1:0]  mask_idx;
  logic              wen, halt, go, alt;

  assign hit_lock = (reg_addr == ADDR_W'(ADDR_LOCK));
  assign hit_ctrl = (reg_addr == ADDR_W'(ADDR_CTRL));
  assign mask_off = reg_addr - ADDR_W'(ADDR_MASK0);
  assign hit_mask = (reg_addr >= ADDR_W'(ADDR_MASK0)) &&
                    (mask_off < ADDR_W'(NUM_POLICY));
  assign mask_idx = POL_W'(mask_off);

  logic [NUM_POLICY-1:0][NUM_CLK-1:0] masks;

  pmask_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_i    (reg_we && hit_lock),
    .wdata_i (reg_wdata),
    .wen_o   (wen)
  );

  pmask_engine u_engine (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_i   (reg_we && hit_ctrl && wen),
    .cmd_i  (reg_wdata[3:0]),
    .halt_o (halt),
    .go_o   (go),
    .alt_o  (alt)
  );

  pmask_bank #(
    .NUM_POLICY (NUM_POLICY),
    .NUM_CLK    (NUM_CLK)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_i    (reg_we && hit_mask && wen && halt),
    .idx_i   (mask_idx),
    .wdata_i (reg_wdata[NUM_CLK-1:0]),
    .masks_o (masks)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit_lock)      reg_rdata[0] = wen;
    else if (hit_ctrl) begin
      reg_rdata[CTL_HALT] = halt;
      reg_rdata[CTL_GO]   = go;
      reg_rdata[CTL_AUTO] = alt;
    end
    else if (hit_mask) reg_rdata[NUM_CLK-1:0] = masks[mask_idx];
  end

  // enable output register
  logic [NUM_CLK-1:0] en_q, en_d;
  logic               en_load;

  assign en_load = !halt || go;

  always_comb begin
    en_d = en_q;
    if (en_load) en_d = masks[active_policy];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) en_q <= '0;
    else          en_q <= en_d;
  end

  assign clk_en = en_q;

  // R3: locked block keeps masks
  a_r3_locked_masks: assert property (@(posedge clk) disable iff (!rst_i_n)
    !wen |=> $stable(masks));
  // R4: running engine keeps masks
  a_r4_run_masks: assert property (@(posedge clk) disable iff (!rst_i_n)
    !halt |=> $stable(masks));
  // R7: halted engine holds enables
  a_r7_hold_en: assert property (@(posedge clk) disable iff (!rst_i_n)
    (halt && !go) |=> $stable(clk_en));
  // R1: running enables track the selected mask
  a_r1_track: assert property (@(posedge clk) disable iff (!rst_i_n)
    !halt |=> clk_en == $past(masks[active_policy]));
endmodule

// File: tb/pmask_clk_ctrl_test.sv
module pmask_clk_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic [1:0]  active_policy;
  logic [15:0] clk_en;

  int errors = 0;
  int checks = 0;
  logic [15:0] model [4];
  logic [15:0] last_en;

  localparam logic [31:0] PW = 32'hA5C3E100;

  pmask_clk_ctrl uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_we        (reg_we),
    .reg_rdata     (reg_rdata),
    .active_policy (active_policy),
    .clk_en        (clk_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0; active_policy = 2'd0;
    for (int p = 0; p < 4; p++) model[p] = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R8 enables low in reset", {16'h0, clk_en}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 enables from reset mask", {16'h0, clk_en}, 32'h0000FFFF);
    rd("R8 lock flag clear", 4'd0, 32'h0);
    rd("R8 engine running", 4'd1, 32'h0);
    for (int p = 0; p < 4; p++) rd("R8 mask all ones", 4'(2 + p), 32'h0000FFFF);

    // R3: locked writes dropped
    wr(4'd1, 32'h1);
    rd("R3 halt dropped while locked", 4'd1, 32'h0);

    // R2: wrong then right password
    wr(4'd0, 32'h12345601);
    rd("R2 wrong password", 4'd0, 32'h0);
    wr(4'd0, PW | 32'h1);
    rd("R2 right password", 4'd0, 32'h1);

    // R4: mask write while running ignored
    wr(4'd3, 32'h0000ABCD);
    rd("R4 mask unchanged running", 4'd3, 32'h0000FFFF);
    check("R4 enables unchanged", {16'h0, clk_en}, 32'h0000FFFF);

    // R4: halt, then write masks
    wr(4'd1, 32'h1);
    rd("R4 halted", 4'd1, 32'h1);
    for (int p = 0; p < 4; p++) begin
      model[p] = 16'((32'h3C5A * (p + 1)) ^ (32'h0101 << p));
      wr(4'(2 + p), {16'hDEAD, model[p]});
    end
    for (int p = 0; p < 4; p++) rd("R1 mask readback", 4'(2 + p), {16'h0, model[p]});

    // R7: halted enables hold across policy sweep
    for (int p = 0; p < 4; p++) begin
      active_policy = 2'(p);
      @(negedge clk);
      check("R7 hold while halted", {16'h0, clk_en}, 32'h0000FFFF);
    end

    // R5: malformed go commands ignored
    wr(4'd1, 32'hE);
    rd("R5 both modes rejected", 4'd1, 32'h1);
    wr(4'd1, 32'h2);
    rd("R5 no mode rejected", 4'd1, 32'h1);
    wr(4'd1, 32'h7);
    rd("R5 halt bit set rejected", 4'd1, 32'h1);
    check("R7 hold after rejected go", {16'h0, clk_en}, 32'h0000FFFF);

    // R6: auto go
    active_policy = 2'd2;
    wr(4'd1, 32'h6);
    rd("R6 go visible one cycle", 4'd1, 32'h3);
    @(negedge clk);
    rd("R6 go cleared and running", 4'd1, 32'h0);
    check("R6 enables reload", {16'h0, clk_en}, {16'h0, model[2]});

    // R1: running policy sweep
    for (int p = 0; p < 4; p++) begin
      active_policy = 2'(p);
      @(negedge clk);
      check("R1 enables follow policy", {16'h0, clk_en}, {16'h0, model[p]});
    end

    // R3: halt, relock, mask write dropped
    wr(4'd1, 32'h1);
    wr(4'd0, 32'h00000001);
    rd("R3 bad pw relocks", 4'd0, 32'h0);
    wr(4'd2, 32'h00001234);
    rd("R3 mask dropped while locked", 4'd2, {16'h0, model[0]});
    wr(4'd1, 32'hA);
    rd("R3 go dropped while locked", 4'd1, 32'h1);

    // R5: alternate go after unlock, new mask applied
    wr(4'd0, PW | 32'h1);
    model[1] = 16'h00F0;
    wr(4'd3, {16'h0, model[1]});
    active_policy = 2'd0;
    @(negedge clk);
    last_en = clk_en;
    check("R7 hold during edit", {16'h0, last_en}, {16'h0, model[3]});
    active_policy = 2'd1;
    wr(4'd1, 32'hA);
    rd("R5 alt go pending", 4'd1, 32'h7);
    @(negedge clk);
    rd("R5 alt mode recorded", 4'd1, 32'h4);
    check("R6 alt reload", {16'h0, clk_en}, 32'h000000F0);

    // R2: correct pw with flag 0 locks
    wr(4'd0, PW);
    rd("R2 lock via flag", 4'd0, 32'h0);
    rd("R1 unmapped reads zero", 4'd9, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule